// File: doc/BRIEF.md
# Two-Wire Serial Memory Device Select and Address Pointer

This block sits at the front of a two-wire serial memory slave. It oversamples the clock and data lines of the bus and detects start and stop conditions. It then shifts in the first byte after each start and decides whether that byte addresses this device. A byte matches when its top four bits carry the fixed device-type code and its next three bits equal the levels on three strap inputs. The block acknowledges a matching byte by pulling the data line low through an open-drain output enable.

The lowest bit of the matching byte sets the transfer direction, and the block latches it. On a write, the block goes on to take two address bytes and acknowledges each one. It then loads them together into a 16-bit word pointer, with the first byte as the upper half. A memory back end reads the pointer and the direction, uses the strobes to learn when a device select or a pointer load has happened, and steps the pointer with an increment input. The pointer wraps inside this device only, so the strap bits never act as a carry target.

Top module: `i2c_mem_addr_front`

## Requirements
- R1: The first byte after a start is the control byte. Its bits 7:4 must equal the device code (default binary 1010), or the block gives no acknowledge.
- R2: Control bits 3:1 must equal `chip_sel[2]`, `chip_sel[1]` and `chip_sel[0]`, in that order, or the block gives no acknowledge.
- R3: On a matching control byte, bit 0 is latched into `rd_nwr` (1 means read, 0 means write), and `sel_stb` pulses for one clock. `rd_nwr` changes at no other time.
- R4: After a matching write control byte, the next byte supplies pointer bits 15:8 and the byte after it supplies bits 7:0. All 16 bits are kept. `ptr_load` pulses for one clock when the pointer is loaded.
- R5: Each of the two address bytes is acknowledged.
- R6: `word_ptr` changes only on a `ptr_load` or a `ptr_inc`. It stays unchanged after the high address byte alone.
- R7: A stop seen mid-byte returns the block to idle, so the partly received byte has no effect. A start seen mid-byte begins a fresh control byte.
- R8: A one-clock `ptr_inc` adds one to `word_ptr`, and 0xFFFF wraps to 0x0000.
- R9: `sda_oe` changes only while the sampled SCL is low. The acknowledge is released after the ninth clock.
- R10: After a control byte that does not match, no later byte is acknowledged until the next start. The pointer and the direction stay unchanged.
- R11: After reset, `word_ptr` is 0, `rd_nwr` is 0 and `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| chip_sel | input | 3 | Strap levels compared with control bits 3:1 |
| ptr_inc | input | 1 | Back-end request to step the pointer |
| sda_oe | output | 1 | Pulls the data line low when 1 |
| word_ptr | output | 16 | Word address pointer |
| rd_nwr | output | 1 | Latched direction, 1 means read |
| sel_stb | output | 1 | One-clock pulse on a matching control byte |
| ptr_load | output | 1 | One-clock pulse when the pointer is loaded |

## Verification
The bench builds the block with its default parameters: device code 1010 and a two-stage input synchronizer. Each bus clock phase is eight system clocks, which leaves room for the synchronizer and edge-detector latency before the bench drives data or samples the acknowledge. With these values the bench can reach every strap combination, both directions, aborts by start and by stop in the middle of a byte, and the pointer wrap from 0xFFFF.

// File: rtl/i2c_mem_addr_front.sv
module i2c_mem_addr_front #(
  parameter logic [3:0] DEV_CODE = 4'b1010,
  parameter int SYNC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  input  logic [2:0]  chip_sel,
  input  logic        ptr_inc,
  output logic        sda_oe,
  output logic [15:0] word_ptr,
  output logic        rd_nwr,
  output logic        sel_stb,
  output logic        ptr_load
);
  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_AHI, S_ALO, S_HOLD} st_t;

  logic [SYNC-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;
  logic [3:0] cnt;
  logic [7:0] sr, hi;
  st_t st;

  wire scl_s = scl_sh[SYNC-1];
  wire sda_s = sda_sh[SYNC-1];
  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire start_c = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c  = scl_s & scl_p & ~sda_p & sda_s;
  wire hit = (sr[7:4] == DEV_CODE) && (sr[3:1] == chip_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_in};
      sda_sh <= {sda_sh[SYNC-2:0], sda_in};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      sr <= '0;
      hi <= '0;
      sda_oe <= 1'b0;
      word_ptr <= '0;
      rd_nwr <= 1'b0;
      sel_stb <= 1'b0;
      ptr_load <= 1'b0;
    end else begin
      sel_stb <= 1'b0;
      ptr_load <= 1'b0;
      if (ptr_inc) word_ptr <= word_ptr + 16'd1;
      if (start_c || stop_c) begin
        st <= start_c ? S_CTRL : S_IDLE;
        cnt <= '0;
        sda_oe <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (cnt < 4'd8) sr <= {sr[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end else if (scl_fall) begin
          if (cnt == 4'd8) begin
            case (st)
              S_CTRL: begin
                if (hit) begin
                  sda_oe <= 1'b1;
                  rd_nwr <= sr[0];
                  sel_stb <= 1'b1;
                  st <= sr[0] ? S_HOLD : S_AHI;
                end else begin
                  st <= S_HOLD;
                end
              end
              S_AHI: begin
                sda_oe <= 1'b1;
                hi <= sr;
                st <= S_ALO;
              end
              S_ALO: begin
                sda_oe <= 1'b1;
                word_ptr <= {hi, sr};
                ptr_load <= 1'b1;
                st <= S_HOLD;
              end
              default: ;
            endcase
          end else if (cnt == 4'd9) begin
            sda_oe <= 1'b0;
            cnt <= '0;
          end
        end
      end
    end
  end
endmodule

module i2c_mem_addr_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        sda_oe,
  input logic [15:0] word_ptr,
  input logic        rd_nwr,
  input logic        sel_stb,
  input logic        ptr_load,
  input logic        ptr_inc
);
  assert_ptr_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_ptr) |-> (ptr_load || $past(ptr_inc)));
  assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ptr_inc && word_ptr == 16'hFFFF) && !ptr_load) |-> (word_ptr == 16'h0000));
  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));
  assert_dir_on_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_nwr) |-> sel_stb);
  assert_sel_acks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_stb |-> sda_oe);
endmodule

bind i2c_mem_addr_front i2c_mem_addr_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .word_ptr(word_ptr), .rd_nwr(rd_nwr), .sel_stb(sel_stb),
  .ptr_load(ptr_load), .ptr_inc(ptr_inc)
);

// File: tb/tb_i2c_mem_addr_front.sv
module tb_i2c_mem_addr_front;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, ptr_inc = 1'b0;
  logic [2:0] chip_sel = 3'd0;
  logic sda_oe, rd_nwr, sel_stb, ptr_load;
  logic [15:0] word_ptr;
  wire sda_line = sda_m & ~sda_oe;

  int tests = 0, fails = 0, settle = 0;
  int sel_cnt = 0, load_cnt = 0;
  logic [15:0] exp_ptr = '0;
  logic exp_dir = 1'b0;

  always #2 clk = ~clk;

  i2c_mem_addr_front dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .chip_sel(chip_sel), .ptr_inc(ptr_inc), .sda_oe(sda_oe),
    .word_ptr(word_ptr), .rd_nwr(rd_nwr), .sel_stb(sel_stb), .ptr_load(ptr_load)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (sel_stb) sel_cnt++;
      if (ptr_load) load_cnt++;
      if (settle > 0) settle--;
      else begin
        check(word_ptr == exp_ptr, "R6 per-clock pointer", word_ptr, exp_ptr);
        check(rd_nwr == exp_dir, "R3 per-clock direction", rd_nwr, exp_dir);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    if (!scl) begin
      tick(4); sda_m = 1'b1; tick(4); scl = 1'b1;
    end
    tick(4); sda_m = 1'b0; tick(8); scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(4); sda_m = 1'b0; tick(4); scl = 1'b1; tick(4); sda_m = 1'b1; tick(8);
  endtask

  task automatic send_bit(input logic b);
    tick(4); sda_m = b; tick(4); scl = 1'b1; tick(8); scl = 1'b0;
  endtask

  task automatic send8(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic recv_ack(output bit ack);
    tick(4); sda_m = 1'b1; tick(4); scl = 1'b1; tick(3);
    @(negedge clk); ack = !sda_line;
    tick(4); scl = 1'b0;
    tick(6);
    check(sda_oe == 1'b0, "R9 ack released", sda_oe, 0);
  endtask

  task automatic do_write(input logic [3:0] code, input logic [2:0] sel,
                          input logic [7:0] hi, input logic [7:0] lo);
    bit m, a;
    m = (code == 4'b1010) && (sel == chip_sel);
    bus_start();
    send8({code, sel, 1'b0});
    if (m) begin exp_dir = 1'b0; settle = 8; end
    recv_ack(a);
    check(a == m, m ? "R1 R2 control ack" : "R1 R2 R10 no ack", a, m);
    send8(hi);
    recv_ack(a);
    check(a == m, "R5 R10 high byte ack", a, m);
    check(word_ptr == exp_ptr, "R6 unchanged after high byte", word_ptr, exp_ptr);
    send8(lo);
    if (m) begin exp_ptr = {hi, lo}; settle = 8; end
    recv_ack(a);
    check(a == m, "R5 R10 low byte ack", a, m);
    check(word_ptr == exp_ptr, "R4 pointer value", word_ptr, exp_ptr);
    bus_stop();
  endtask

  task automatic do_read_sel(input logic [3:0] code, input logic [2:0] sel);
    bit m, a;
    m = (code == 4'b1010) && (sel == chip_sel);
    bus_start();
    send8({code, sel, 1'b1});
    if (m) begin exp_dir = 1'b1; settle = 8; end
    recv_ack(a);
    check(a == m, "R1 R2 read control ack", a, m);
    check(rd_nwr == exp_dir, "R3 direction", rd_nwr, exp_dir);
    bus_stop();
  endtask

  task automatic pulse_inc();
    ptr_inc = 1'b1; exp_ptr = exp_ptr + 16'd1; settle = 3;
    tick(1); ptr_inc = 1'b0; tick(4);
  endtask

  initial begin
    #(4 * 180000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit a;
    int s0, l0;
    tick(5);
    check(word_ptr == 16'h0 && rd_nwr == 1'b0 && sda_oe == 1'b0, "R11 reset state",
          {word_ptr, rd_nwr, sda_oe}, 0);
    rst_n = 1'b1;
    tick(5);

    s0 = sel_cnt; l0 = load_cnt;
    do_write(4'b1010, 3'd0, 8'h12, 8'h34);
    check(word_ptr == 16'h1234, "R4 high byte first", word_ptr, 16'h1234);
    check(sel_cnt - s0 == 1, "R3 sel_stb once", sel_cnt - s0, 1);
    check(load_cnt - l0 == 1, "R4 ptr_load once", load_cnt - l0, 1);

    do_write(4'b1011, 3'd0, 8'hAA, 8'h55);
    do_write(4'b0010, 3'd0, 8'hAA, 8'h55);
    check(word_ptr == 16'h1234, "R10 pointer kept after mismatch", word_ptr, 16'h1234);

    for (int s = 0; s < 8; s++) begin
      chip_sel = 3'(s);
      tick(4);
      do_write(4'b1010, 3'(s) ^ 3'd4, 8'h0F, 8'hF0);
      do_write(4'b1010, 3'(s), 8'(s * 17), 8'(255 - s));
      do_read_sel(4'b1010, 3'(s) ^ 3'd1);
      do_read_sel(4'b1010, 3'(s));
    end

    chip_sel = 3'd5;
    tick(4);
    do_read_sel(4'b1010, 3'd5);
    check(rd_nwr == 1'b1, "R3 read latched", rd_nwr, 1);

    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    send8({4'b1010, 3'd5, 1'b0});
    exp_dir = 1'b0; settle = 8;
    recv_ack(a);
    check(a == 1'b1, "R7 restart mid-byte then ack", a, 1);
    send8(8'hBE);
    recv_ack(a);
    check(a == 1'b1, "R5 high byte ack after restart", a, 1);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_stop();
    tick(6);
    check(word_ptr == exp_ptr, "R7 stop mid-byte leaves pointer", word_ptr, exp_ptr);
    check(sda_oe == 1'b0, "R7 idle after stop", sda_oe, 0);
    scl = 1'b0;
    tick(4);
    send8(8'h00);
    recv_ack(a);
    check(a == 1'b0, "R7 idle ignores bits without start", a, 0);
    scl = 1'b1; sda_m = 1'b1; tick(8);

    do_write(4'b1010, 3'd5, 8'hFF, 8'hFF);
    pulse_inc();
    check(word_ptr == 16'h0000, "R8 wrap to zero", word_ptr, 0);
    pulse_inc();
    check(word_ptr == 16'h0001, "R8 increment", word_ptr, 1);
    do_read_sel(4'b1010, 3'd5);
    check(rd_nwr == 1'b1, "R8 strap match unaffected by wrap", rd_nwr, 1);

    tick(20);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule